// File: doc/BRIEF.md
# Arithmetic Condition Evaluator

This block forms the sum, the difference or a bitwise combination of two operands. From the same datapath it derives the carry, the unsigned overflow and the signed overflow. It then decides whether a selected test on that outcome holds. The test is chosen by a 3-bit code and a negate bit. Downstream logic uses the single-bit verdict to decide whether to skip the next operation or to take a branch. The block itself performs neither action.

The arithmetic and the decoding are purely combinational. One register stage holds the result, the two overflow flags, the verdict and an "undefined code" flag. The stage loads on every cycle in which the input strobe is high and keeps its value otherwise. Only the codes that make sense for a bitwise combination are accepted with a logical operation. Any other code returns a false verdict and raises the undefined flag.

Top module: `alu_cc_eval`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every registered output (`out_valid`, `result`, `cond_true`, `uns_ovf`, `sgn_ovf`, `cond_undef`) becomes 0.
- R2: `out_valid` is high in the cycle after `in_valid` was high, and low otherwise. The other outputs take the values for the inputs sampled with `in_valid` high, one cycle later. They keep their values while `in_valid` is low.
- R3: `op_sel` selects the operation: 0 gives `op_a + op_b`, 1 gives `op_a - op_b`, 2 gives `op_a & op_b`, and 3 gives `op_a ^ op_b`. All four are modulo 2^W.
- R4: Unsigned overflow is the carry out of the addition for op 0. For op 1 it is set exactly when `op_b` is greater than `op_a` as unsigned numbers.
- R5: Signed overflow is set when the true two's-complement sum (op 0) or difference (op 1) cannot be represented in W bits.
- R6: For ops 2 and 3, both overflow flags are 0.
- R7: Code 0 never holds. Code 1 holds when all W result bits are 0.
- R8: Code 2 holds when the result's top bit XOR signed overflow is 1. Code 3 holds when code 1 or code 2 holds.
- R9: Code 4 holds on no unsigned overflow for op 0, and on unsigned overflow for op 1. Code 5 holds when the result is zero or the code-4 term for that op holds.
- R10: Code 6 holds on signed overflow. Code 7 holds when the result's bit 0 is 1.
- R11: When `cond_neg` is 1, the verdict of any accepted code is inverted, so code 0 with `cond_neg` = 1 always holds.
- R12: With op 2 or 3, codes 4, 5 and 6 give `cond_true` = 0 and `cond_undef` = 1 whatever `cond_neg` is. In every other case `cond_undef` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe; loads the output stage |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| op_sel | input | 2 | Operation: 0 add, 1 subtract, 2 AND, 3 XOR |
| cond_sel | input | 3 | Condition code 0..7 |
| cond_neg | input | 1 | Invert the selected condition |
| out_valid | output | 1 | Registered outputs are fresh |
| result | output | W | Registered result |
| cond_true | output | 1 | Registered verdict |
| uns_ovf | output | 1 | Registered unsigned overflow |
| sgn_ovf | output | 1 | Registered signed overflow |
| cond_undef | output | 1 | Code was not accepted for a logical op |

## Verification
The sign test of codes 2 and 3 and the signed-overflow detector act in the same cycle whenever an add or subtract wraps. The verdict must then follow the XOR of the two and not the raw sign bit. The bench forces this with directed operands at the signed limits, such as the largest positive value plus one, and with random operands drawn often from those limits. A second coincidence is the rejection of an undefined logical code while the negate bit is set. The bench judges it by checking that the verdict stays 0 rather than being inverted to 1.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_XOR = 2'd3
  } op_e;

  localparam int unsigned CODE_W   = 3;
  localparam int unsigned NUM_CODE = 1 << CODE_W;

  localparam logic [CODE_W-1:0] CC_NEVER = 3'd0;
  localparam logic [CODE_W-1:0] CC_ZERO  = 3'd1;
  localparam logic [CODE_W-1:0] CC_LT    = 3'd2;
  localparam logic [CODE_W-1:0] CC_LE    = 3'd3;
  localparam logic [CODE_W-1:0] CC_UOV   = 3'd4;
  localparam logic [CODE_W-1:0] CC_ZUOV  = 3'd5;
  localparam logic [CODE_W-1:0] CC_SOV   = 3'd6;
  localparam logic [CODE_W-1:0] CC_ODD   = 3'd7;

  function automatic logic is_logical(input op_e op);
    return (op == OP_AND) || (op == OP_XOR);
  endfunction

  function automatic logic code_ok_for_logic(input logic [CODE_W-1:0] c);
    return !((c == CC_UOV) || (c == CC_ZUOV) || (c == CC_SOV));
  endfunction

endpackage

// File: rtl/alu_cc_datapath.sv
module alu_cc_datapath
  import alu_cc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  op_e          op,
  output logic [W-1:0] res,
  output logic         carry
);

  localparam int unsigned SW = W + 1;

  function automatic logic [SW-1:0] add_carry(input logic [W-1:0] x,
                                              input logic [W-1:0] y,
                                              input logic         cin);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  endfunction

  logic          is_sub;
  logic [W-1:0]  b_eff;
  logic [SW-1:0] sum_w;

  assign is_sub = (op == OP_SUB);
  assign b_eff  = is_sub ? ~b : b;
  assign sum_w  = add_carry(a, b_eff, is_sub);

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB: res = sum_w[W-1:0];
      OP_AND:         res = a & b;
      default:        res = a ^ b;
    endcase
  end

  assign carry = is_logical(op) ? 1'b0 : sum_w[W];

endmodule

// File: rtl/alu_cc_ovf.sv
module alu_cc_ovf
  import alu_cc_pkg::*;
(
  input  logic a_msb,
  input  logic b_msb,
  input  logic r_msb,
  input  logic carry,
  input  op_e  op,
  output logic uns_ovf,
  output logic sgn_ovf
);

  logic add_sv;
  logic sub_sv;

  assign add_sv = (a_msb == b_msb) && (r_msb != a_msb);
  assign sub_sv = (a_msb != b_msb) && (r_msb != a_msb);

  always_comb begin
    unique case (op)
      OP_ADD: begin
        uns_ovf = carry;
        sgn_ovf = add_sv;
      end
      OP_SUB: begin
        uns_ovf = ~carry;
        sgn_ovf = sub_sv;
      end
      default: begin
        uns_ovf = 1'b0;
        sgn_ovf = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/alu_cc_decode.sv
module alu_cc_decode
  import alu_cc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]      res,
  input  logic              uns_ovf,
  input  logic              sgn_ovf,
  input  op_e               op,
  input  logic [CODE_W-1:0] code,
  input  logic              neg,
  output logic              hit,
  output logic              undef
);

  logic                is_zero;
  logic                lt_term;
  logic                u_term;
  logic [NUM_CODE-1:0] terms;
  logic                raw_hit;

  assign is_zero = (res == '0);
  assign lt_term = res[W-1] ^ sgn_ovf;
  assign u_term  = (op == OP_SUB) ? uns_ovf : ~uns_ovf;

  always_comb begin
    terms           = '0;
    terms[CC_NEVER] = 1'b0;
    terms[CC_ZERO]  = is_zero;
    terms[CC_LT]    = lt_term;
    terms[CC_LE]    = is_zero | lt_term;
    terms[CC_UOV]   = u_term;
    terms[CC_ZUOV]  = is_zero | u_term;
    terms[CC_SOV]   = sgn_ovf;
    terms[CC_ODD]   = res[0];
  end

  assign raw_hit = terms[code];
  assign undef   = is_logical(op) && !code_ok_for_logic(code);
  assign hit     = undef ? 1'b0 : (raw_hit ^ neg);

endmodule

// File: rtl/alu_cc_eval.sv
module alu_cc_eval
  import alu_cc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic [1:0]    op_sel,
  input  logic [2:0]    cond_sel,
  input  logic          cond_neg,
  output logic          out_valid,
  output logic [W-1:0]  result,
  output logic          cond_true,
  output logic          uns_ovf,
  output logic          sgn_ovf,
  output logic          cond_undef
);

  op_e         op;
  logic [W-1:0] res_c;
  logic         carry_c;
  logic         uov_c;
  logic         sov_c;
  logic         hit_c;
  logic         undef_c;

  assign op = op_e'(op_sel);

  alu_cc_datapath #(.W(W)) u_dp (
    .a     (op_a),
    .b     (op_b),
    .op    (op),
    .res   (res_c),
    .carry (carry_c)
  );

  alu_cc_ovf u_ovf (
    .a_msb   (op_a[W-1]),
    .b_msb   (op_b[W-1]),
    .r_msb   (res_c[W-1]),
    .carry   (carry_c),
    .op      (op),
    .uns_ovf (uov_c),
    .sgn_ovf (sov_c)
  );

  alu_cc_decode #(.W(W)) u_dec (
    .res     (res_c),
    .uns_ovf (uov_c),
    .sgn_ovf (sov_c),
    .op      (op),
    .code    (cond_sel),
    .neg     (cond_neg),
    .hit     (hit_c),
    .undef   (undef_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      result     <= '0;
      cond_true  <= 1'b0;
      uns_ovf    <= 1'b0;
      sgn_ovf    <= 1'b0;
      cond_undef <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result     <= res_c;
        cond_true  <= hit_c;
        uns_ovf    <= uov_c;
        sgn_ovf    <= sov_c;
        cond_undef <= undef_c;
      end
    end
  end

  // R2: strobe reaches out_valid one cycle later
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2: outputs hold while no strobe
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(cond_true) && $stable(cond_undef)));

  // R6: logical ops carry no overflow
  a_r6_logic_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel[1]) |=> (!uns_ovf && !sgn_ovf));

  // R7: code 0 without negation never holds
  a_r7_never: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond_sel == 3'd0 && !cond_neg) |=> !cond_true);

  // R11: code 0 with negation always holds
  a_r11_always: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond_sel == 3'd0 && cond_neg) |=> cond_true);

  // R12: undefined verdict is never true
  a_r12_undef_false: assert property (@(posedge clk) disable iff (!rst_n)
    cond_undef |-> !cond_true);

  // R12: undefined only flagged for logical ops
  a_r12_undef_logic_only: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_sel[1]) |=> !cond_undef);

endmodule

// File: tb/alu_cc_eval_tb.sv
module alu_cc_eval_tb;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [1:0]   op_sel = '0;
  logic [2:0]   cond_sel = '0;
  logic         cond_neg = 1'b0;
  logic         out_valid;
  logic [W-1:0] result;
  logic         cond_true;
  logic         uns_ovf;
  logic         sgn_ovf;
  logic         cond_undef;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  alu_cc_eval #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .cond_sel(cond_sel), .cond_neg(cond_neg),
    .out_valid(out_valid), .result(result), .cond_true(cond_true),
    .uns_ovf(uns_ovf), .sgn_ovf(sgn_ovf), .cond_undef(cond_undef)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] m_res(input logic [W-1:0] a, b, input logic [1:0] op);
    case (op)
      2'd0: return a + b;
      2'd1: return a - b;
      2'd2: return a & b;
      default: return a ^ b;
    endcase
  endfunction

  function automatic logic m_uov(input logic [W-1:0] a, b, input logic [1:0] op);
    logic [W:0] wide;
    wide = {1'b0, a} + {1'b0, b};
    if (op == 2'd0) return wide[W];
    if (op == 2'd1) return b > a;
    return 1'b0;
  endfunction

  function automatic logic m_sov(input logic [W-1:0] a, b, input logic [1:0] op);
    longint sa, sb, t;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    if (op == 2'd0) t = sa + sb;
    else if (op == 2'd1) t = sa - sb;
    else return 1'b0;
    return (t > 64'sd2147483647) || (t < -64'sd2147483648);
  endfunction

  function automatic logic m_undef(input logic [1:0] op, input logic [2:0] c);
    return op[1] && (c == 3'd4 || c == 3'd5 || c == 3'd6);
  endfunction

  function automatic logic m_hit(input logic [W-1:0] a, b, input logic [1:0] op,
                                 input logic [2:0] c, input logic f);
    logic [W-1:0] r;
    logic z, u, s, lt, v;
    if (m_undef(op, c)) return 1'b0;
    r  = m_res(a, b, op);
    z  = (r == 0);
    u  = m_uov(a, b, op);
    s  = m_sov(a, b, op);
    lt = r[W-1] != s;
    case (c)
      3'd0: v = 1'b0;
      3'd1: v = z;
      3'd2: v = lt;
      3'd3: v = z || lt;
      3'd4: v = (op == 2'd1) ? u : !u;
      3'd5: v = z || ((op == 2'd1) ? u : !u);
      3'd6: v = s;
      default: v = r[0];
    endcase
    return f ? !v : v;
  endfunction

  function automatic string cond_tag(input logic [2:0] c, input logic f);
    if (f) return "R11";
    case (c)
      3'd0, 3'd1: return "R7";
      3'd2, 3'd3: return "R8";
      3'd4, 3'd5: return "R9";
      default:    return "R10";
    endcase
  endfunction

  task automatic run(input logic [W-1:0] a, b, input logic [1:0] op,
                     input logic [2:0] c, input logic f);
    in_valid = 1'b1; op_a = a; op_b = b; op_sel = op; cond_sel = c; cond_neg = f;
    @(negedge clk);
    chk("R2 valid", {31'd0, out_valid}, 32'd1);
    chk("R3 result", result, m_res(a, b, op));
    chk(op[1] ? "R6 uov" : "R4 uov", {31'd0, uns_ovf}, {31'd0, m_uov(a, b, op)});
    chk(op[1] ? "R6 sov" : "R5 sov", {31'd0, sgn_ovf}, {31'd0, m_sov(a, b, op)});
    chk("R12 undef", {31'd0, cond_undef}, {31'd0, m_undef(op, c)});
    chk(m_undef(op, c) ? "R12 cond" : cond_tag(c, f), {31'd0, cond_true},
        {31'd0, m_hit(a, b, op, c, f)});
  endtask

  function automatic logic [W-1:0] pick();
    case ($urandom_range(0, 7))
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h7FFF_FFFF;
      4: return 32'd1;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    logic [W-1:0] keep;
    void'($urandom(32'd2024));
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 valid", {31'd0, out_valid}, 32'd0);
    chk("R1 result", result, 32'd0);
    chk("R1 flags", {27'd0, cond_true, uns_ovf, sgn_ovf, cond_undef, out_valid}, 32'd0);
    rst_n = 1'b1;

    // R5/R8: overflow and sign in the same cycle
    run(32'h7FFF_FFFF, 32'd1, 2'd0, 3'd2, 1'b0);
    run(32'h8000_0000, 32'd1, 2'd1, 3'd3, 1'b0);
    run(32'h8000_0000, 32'h8000_0000, 2'd0, 3'd6, 1'b0);
    // R4/R9: borrow and zero
    run(32'd3, 32'd5, 2'd1, 3'd4, 1'b0);
    run(32'd5, 32'd5, 2'd1, 3'd5, 1'b0);
    run(32'hFFFF_FFFF, 32'd1, 2'd0, 3'd4, 1'b0);
    run(32'hFFFF_FFFF, 32'd1, 2'd0, 3'd5, 1'b1);
    // R7/R10/R11
    run(32'd9, 32'd9, 2'd1, 3'd1, 1'b0);
    run(32'd2, 32'd1, 2'd0, 3'd7, 1'b0);
    run(32'd2, 32'd1, 2'd0, 3'd0, 1'b1);
    run(32'd2, 32'd1, 2'd0, 3'd0, 1'b0);
    // R6/R12: logical, undefined codes with negate
    run(32'hF0F0_F0F0, 32'h0F0F_0F0F, 2'd2, 3'd1, 1'b0);
    run(32'hFFFF_FFFF, 32'h7FFF_FFFF, 2'd3, 3'd2, 1'b0);
    run(32'hFFFF_FFFF, 32'h7FFF_FFFF, 2'd3, 3'd4, 1'b1);
    run(32'h1234_5678, 32'h0000_0001, 2'd2, 3'd6, 1'b1);
    run(32'h1234_5678, 32'h0000_0001, 2'd2, 3'd5, 1'b0);

    // R2: hold while strobe low
    keep = result;
    in_valid = 1'b0; op_a = 32'h5555_5555; op_b = 32'h1; op_sel = 2'd0;
    @(negedge clk);
    chk("R2 nv", {31'd0, out_valid}, 32'd0);
    chk("R2 hold", result, keep);

    for (int i = 0; i < 400; i++) begin
      run(pick(), pick(), 2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)),
          1'($urandom_range(0, 1)));
    end

    // R1: reset clears after activity
    in_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    chk("R1 again", {result[3:0], 23'd0, cond_true, uns_ovf, sgn_ovf, cond_undef, out_valid}, 32'd0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule